// File: doc/BRIEF.md
# Single-Beat Memory-Mapped Request Gate

This block sits between a memory-mapped master and a packet-oriented request channel, for example the transaction layer of a serial interconnect. The master presents one request per beat. Each request carries a byte address, a length of 1 to 16 dwords and a byte-enable vector. The gate checks the request against a set of legality rules. A legal request goes downstream as a descriptor made of the address, the dword length, the enables and a write flag.

Writes leave the gate as soon as the downstream side is ready, and nothing comes back for them. A read makes the gate busy. The gate holds the master off with waitrequest until the matching completion has come back. Completion data arrives one dword per cycle on a plain return port and is handed to the master one cycle later, with a valid strobe.

An illegal request is never forwarded. The gate consumes it in the cycle it is presented, so the master cannot hang, and raises an error strobe in the following cycle.

Top module: `mm_req_gate`

## Requirements
- R1: A request whose burst count is not exactly 1 is illegal.
- R2: A request length of 0, or of more than 16 dwords, is illegal.
- R3: Address bits [5:2] give the dword offset inside a 16-dword window. A request is illegal when this offset plus the length exceeds 16. Offset 15 admits only length 1, and offset 0 admits lengths up to 16.
- R4: On a one-dword request, `q_be` equals `m_byteenable[3:0]` and `q_dw_en` is `16'h0001` when any of those bits is set.
- R5: On a longer request, dword i uses byte-enable bits [4i+3:4i], and those four bits must be all zeros or all ones, or the request is illegal. `q_dw_en[i]` is 1 for an all-ones dword that lies inside the length. Every bit of `q_dw_en` at or beyond the length is 0. `q_be` is four copies of bit 0 of `q_dw_en`.
- R6: An illegal request keeps `q_valid` low and `m_waitrequest` low in the cycle it is presented. This also covers a request with read and write both high. `m_err` is high in exactly the next cycle.
- R7: While the gate is idle, a legal request drives `q_valid` high in the same cycle, and `m_waitrequest` equals the inverse of `q_ready`. The request is taken at the clock edge where `q_ready` is high.
- R8: Once a read has been taken, `m_waitrequest` stays high and `q_valid` stays low until the last completion dword of that read has been received.
- R9: While a read is outstanding, each cycle with `c_valid` high produces `m_readdatavalid` and `m_readdata` one cycle later, in order. After as many dwords as the read length, the gate is idle again. `c_valid` has no effect while the gate is idle.
- R10: With synchronous reset high, `m_waitrequest` is high. Reset abandons any outstanding read, and `m_waitrequest` is low after release.
- R11: A taken write does not make the gate busy. A request in the next cycle can be taken at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_address | input | 32 | Byte address, dword aligned |
| m_burstcount | input | 4 | Burst count, must be 1 |
| m_length | input | 5 | Request length in dwords |
| m_byteenable | input | 64 | Byte enables, four bits per dword |
| m_waitrequest | output | 1 | Stall toward the master |
| m_readdata | output | 32 | Read data dword |
| m_readdatavalid | output | 1 | Read data strobe |
| m_err | output | 1 | One-cycle strobe for a consumed illegal request |
| q_valid | output | 1 | Descriptor valid |
| q_ready | input | 1 | Downstream accepts the descriptor |
| q_write | output | 1 | Descriptor is a write |
| q_addr | output | 32 | Descriptor byte address |
| q_len | output | 5 | Descriptor length in dwords |
| q_be | output | 4 | First-dword byte enables |
| q_dw_en | output | 16 | Per-dword enables |
| c_valid | input | 1 | Completion dword valid |
| c_data | input | 32 | Completion dword |

## Verification
The hardest situations to reach are those of a read in flight. One is a write that arrives while the gate is busy and must stay blocked. Another is a gap between completion dwords. A third is reset landing halfway through a completion.

The stimulus first issues a read that ends exactly at the window edge, then holds a competing write on the bus while the gate is busy. Next it returns the completion with an idle cycle in the middle. It checks the data order and the busy release on the final dword.

A separate scenario resets the gate after one of two completion dwords has arrived. It then shows that a late completion dword is dropped and that a new write is taken at once.

// File: rtl/mm_gate_pkg.sv
package mm_gate_pkg;
    localparam int unsigned BYTES_PER_DW = 4;

    typedef enum logic {
        GATE_IDLE   = 1'b0,
        GATE_RDWAIT = 1'b1
    } gate_mode_e;
endpackage

// File: rtl/mm_gate_legal.sv
module mm_gate_legal #(
    parameter int unsigned BURST_W = 4,
    parameter int unsigned WIN_DW  = 16,
    localparam int unsigned OFF_W  = $clog2(WIN_DW),
    localparam int unsigned LEN_W  = $clog2(WIN_DW) + 1,
    localparam int unsigned BE_W   = mm_gate_pkg::BYTES_PER_DW * WIN_DW
) (
    input  logic [OFF_W-1:0]   offset,
    input  logic [BURST_W-1:0] burst,
    input  logic [LEN_W-1:0]   len,
    input  logic [BE_W-1:0]    be,
    output logic               legal
);
    localparam logic [LEN_W-1:0] WIN_L  = LEN_W'(WIN_DW);
    localparam logic [LEN_W:0]   WIN_S  = (LEN_W+1)'(WIN_DW);
    localparam int unsigned      BPD    = mm_gate_pkg::BYTES_PER_DW;

    logic [WIN_DW-1:0] be_bad;
    logic [LEN_W:0]    span;
    logic              ok_burst, ok_len, ok_window, ok_enables, multi;

    assign multi = len > LEN_W'(1);

    for (genvar i = 0; i < WIN_DW; i++) begin : g_dw
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        logic [BPD-1:0] bits;
        assign bits      = be[i*BPD +: BPD];
        assign be_bad[i] = multi && (IDX < len) && (|bits) && !(&bits);
    end

    assign span       = {1'b0, {(LEN_W-OFF_W){1'b0}}, offset} + {1'b0, len};
    assign ok_burst   = burst == BURST_W'(1);
    assign ok_len     = (len != '0) && (len <= WIN_L);
    assign ok_window  = span <= WIN_S;
    assign ok_enables = ~|be_bad;
    assign legal      = ok_burst && ok_len && ok_window && ok_enables;
endmodule

// File: rtl/mm_gate_enmap.sv
module mm_gate_enmap #(
    parameter int unsigned WIN_DW = 16,
    localparam int unsigned LEN_W = $clog2(WIN_DW) + 1,
    localparam int unsigned BPD   = mm_gate_pkg::BYTES_PER_DW,
    localparam int unsigned BE_W  = BPD * WIN_DW
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [BE_W-1:0]   be,
    output logic [BPD-1:0]    first_be,
    output logic [WIN_DW-1:0] dw_en
);
    logic single;
    assign single = len == LEN_W'(1);

    for (genvar i = 0; i < WIN_DW; i++) begin : g_dw
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        logic [BPD-1:0] bits;
        assign bits     = be[i*BPD +: BPD];
        assign dw_en[i] = (IDX < len) && (single ? (|bits) : (&bits));
    end

    assign first_be = single ? be[BPD-1:0] : {BPD{dw_en[0]}};
endmodule

// File: rtl/mm_req_gate.sv
module mm_req_gate #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BURST_W = 4,
    parameter int unsigned WIN_DW  = 16,
    localparam int unsigned LEN_W  = $clog2(WIN_DW) + 1,
    localparam int unsigned OFF_W  = $clog2(WIN_DW),
    localparam int unsigned BPD    = mm_gate_pkg::BYTES_PER_DW,
    localparam int unsigned BE_W   = BPD * WIN_DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               m_read,
    input  logic               m_write,
    input  logic [ADDR_W-1:0]  m_address,
    input  logic [BURST_W-1:0] m_burstcount,
    input  logic [LEN_W-1:0]   m_length,
    input  logic [BE_W-1:0]    m_byteenable,
    output logic               m_waitrequest,
    output logic [DATA_W-1:0]  m_readdata,
    output logic               m_readdatavalid,
    output logic               m_err,
    output logic               q_valid,
    input  logic               q_ready,
    output logic               q_write,
    output logic [ADDR_W-1:0]  q_addr,
    output logic [LEN_W-1:0]   q_len,
    output logic [BPD-1:0]     q_be,
    output logic [WIN_DW-1:0]  q_dw_en,
    input  logic               c_valid,
    input  logic [DATA_W-1:0]  c_data
);
    import mm_gate_pkg::*;

    typedef struct packed {
        gate_mode_e        mode;
        logic [LEN_W-1:0]  left;
        logic              rdv;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     rule_ok, req, legal_req, idle, accept, drop;

    mm_gate_legal #(.BURST_W(BURST_W), .WIN_DW(WIN_DW)) u_legal (
        .offset (m_address[2 +: OFF_W]),
        .burst  (m_burstcount),
        .len    (m_length),
        .be     (m_byteenable),
        .legal  (rule_ok)
    );

    mm_gate_enmap #(.WIN_DW(WIN_DW)) u_enmap (
        .len      (m_length),
        .be       (m_byteenable),
        .first_be (q_be),
        .dw_en    (q_dw_en)
    );

    always_comb begin
        req       = m_read | m_write;
        legal_req = rule_ok & ~(m_read & m_write);
        idle      = st_q.mode == GATE_IDLE;
        q_valid   = ~rst & idle & req & legal_req;
        accept    = q_valid & q_ready;
        drop      = ~rst & idle & req & ~legal_req;
        m_waitrequest = rst | ~idle | (req & legal_req & ~q_ready);

        st_d     = st_q;
        st_d.rdv = 1'b0;
        st_d.err = drop;
        if (accept && m_read) begin
            st_d.mode = GATE_RDWAIT;
            st_d.left = m_length;
        end
        if (!idle && c_valid) begin
            st_d.rdv   = 1'b1;
            st_d.rdata = c_data;
            st_d.left  = st_q.left - LEN_W'(1);
            if (st_q.left == LEN_W'(1)) begin
                st_d.mode = GATE_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: GATE_IDLE, left: '0, rdv: 1'b0, rdata: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_write         = m_write;
    assign q_addr          = m_address;
    assign q_len           = m_length;
    assign m_readdata      = st_q.rdata;
    assign m_readdatavalid = st_q.rdv;
    assign m_err           = st_q.err;
endmodule

module mm_req_gate_sva #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_DW = 16,
    localparam int unsigned LEN_W = $clog2(WIN_DW) + 1,
    localparam int unsigned OFF_W = $clog2(WIN_DW)
) (
    input logic              clk,
    input logic              rst,
    input logic              m_waitrequest,
    input logic              m_readdatavalid,
    input logic              m_err,
    input logic              q_valid,
    input logic              q_ready,
    input logic              q_write,
    input logic [ADDR_W-1:0] q_addr,
    input logic [LEN_W-1:0]  q_len,
    input logic [3:0]        q_be,
    input logic              c_valid
);
    localparam logic [LEN_W:0] WIN_S = (LEN_W+1)'(WIN_DW);
    logic [LEN_W:0] span;
    assign span = {1'b0, {(LEN_W-OFF_W){1'b0}}, q_addr[2 +: OFF_W]} + {1'b0, q_len};

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready && !q_write) |=> m_waitrequest);

    // R3
    window_fit_chk: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (q_len != '0 && span <= WIN_S));

    // R5
    dword_be_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_len > LEN_W'(1)) |-> (q_be == 4'h0 || q_be == 4'hF));

    // R6
    no_err_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready) |=> !m_err);

    // R9
    rdv_source_chk: assert property (@(posedge clk) disable iff (rst)
        m_readdatavalid |-> $past(c_valid));

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_ready) |-> m_waitrequest);
endmodule

bind mm_req_gate mm_req_gate_sva #(.ADDR_W(ADDR_W), .WIN_DW(WIN_DW)) u_sva (.*);

// File: tb/test_mm_req_gate.sv
module test_mm_req_gate;
    localparam int ADDR_W = 32, DATA_W = 32, BURST_W = 4, WIN_DW = 16;
    localparam int LEN_W = 5, BE_W = 64;

    logic              clk = 1'b0, rst = 1'b1;
    logic              m_read = 0, m_write = 0;
    logic [ADDR_W-1:0] m_address = '0;
    logic [BURST_W-1:0] m_burstcount = '0;
    logic [LEN_W-1:0]  m_length = '0;
    logic [BE_W-1:0]   m_byteenable = '0;
    logic              m_waitrequest, m_readdatavalid, m_err;
    logic [DATA_W-1:0] m_readdata;
    logic              q_valid, q_write;
    logic              q_ready = 1'b1;
    logic [ADDR_W-1:0] q_addr;
    logic [LEN_W-1:0]  q_len;
    logic [3:0]        q_be;
    logic [WIN_DW-1:0] q_dw_en;
    logic              c_valid = 1'b0;
    logic [DATA_W-1:0] c_data = '0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    mm_req_gate i_mm_req_gate (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic rd, input logic wr, input logic [31:0] addr,
                       input logic [3:0] bc, input logic [4:0] len, input logic [63:0] be);
        m_read = rd; m_write = wr; m_address = addr;
        m_burstcount = bc; m_length = len; m_byteenable = be;
    endtask

    task automatic clear_bus();
        put(0, 0, 32'h0, 4'd0, 5'd0, 64'h0);
        c_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R10 waitrequest in reset", m_waitrequest, 1);
        chk("R10 q_valid in reset", q_valid, 0);
        @(negedge clk); rst = 1'b0; #1;
        chk("R10 waitrequest after release", m_waitrequest, 0);
        chk("R10 readdatavalid after release", m_readdatavalid, 0);
        chk("R10 err after release", m_err, 0);
    endtask

    task automatic t_writes();
        @(negedge clk);
        put(0, 1, 32'h0000_1014, 4'd1, 5'd1, 64'h5);
        q_ready = 1'b1; #1;
        chk("R7 single write valid", q_valid, 1);
        chk("R7 single write no stall", m_waitrequest, 0);
        chk("R4 single byte enables", q_be, 4'h5);
        chk("R4 single dword enable", q_dw_en, 16'h0001);
        chk("R7 write flag", q_write, 1);
        @(negedge clk);
        put(0, 1, 32'h0000_2000, 4'd1, 5'd4, 64'hFFFF_0000_0000_FF0F); #1;
        chk("R11 back-to-back write valid", q_valid, 1);
        chk("R11 back-to-back write no stall", m_waitrequest, 0);
        chk("R5 dword enables within length", q_dw_en, 16'h000D);
        chk("R5 first be replicated", q_be, 4'hF);
        @(negedge clk);
        q_ready = 1'b0;
        put(0, 1, 32'h0000_3000, 4'd1, 5'd2, 64'hFF); #1;
        chk("R7 backpressure stall", m_waitrequest, 1);
        chk("R7 backpressure valid held", q_valid, 1);
        @(negedge clk); #1;
        chk("R7 still stalled", m_waitrequest, 1);
        q_ready = 1'b1; #1;
        chk("R7 released by ready", m_waitrequest, 0);
        @(negedge clk); clear_bus(); #1;
        chk("R6 no err after legal writes", m_err, 0);
    endtask

    task automatic t_bad(input string tag, input logic rd, input logic wr, input logic [31:0] addr,
                         input logic [3:0] bc, input logic [4:0] len, input logic [63:0] be);
        @(negedge clk);
        put(rd, wr, addr, bc, len, be); #1;
        chk({tag, " not forwarded"}, q_valid, 0);
        chk({tag, " consumed"}, m_waitrequest, 0);
        @(negedge clk); clear_bus(); #1;
        chk({tag, " err pulse"}, m_err, 1);
        @(negedge clk); #1;
        chk({tag, " err one cycle"}, m_err, 0);
    endtask

    task automatic t_good_edge(input string tag, input logic [31:0] addr, input logic [4:0] len);
        @(negedge clk);
        put(0, 1, addr, 4'd1, len, {64{1'b1}}); #1;
        chk({tag, " forwarded"}, q_valid, 1);
        @(negedge clk); clear_bus(); #1;
        chk({tag, " no err"}, m_err, 0);
    endtask

    task automatic t_read();
        @(negedge clk);
        put(1, 0, 32'h0000_4034, 4'd1, 5'd3, 64'hFFF); #1;
        chk("R7 read valid", q_valid, 1);
        chk("R7 read not stalled", m_waitrequest, 0);
        @(negedge clk); clear_bus(); #1;
        chk("R8 busy after read", m_waitrequest, 1);
        put(0, 1, 32'h0000_5000, 4'd1, 5'd1, 64'hF); #1;
        chk("R8 write blocked valid", q_valid, 0);
        chk("R8 write blocked stall", m_waitrequest, 1);
        @(negedge clk); clear_bus();
        c_valid = 1'b1; c_data = 32'hA0A0_0001;
        @(negedge clk); c_valid = 1'b0; #1;
        chk("R9 first dword valid", m_readdatavalid, 1);
        chk("R9 first dword data", m_readdata, 32'hA0A0_0001);
        @(negedge clk); #1;
        chk("R9 gap no valid", m_readdatavalid, 0);
        chk("R8 still busy in gap", m_waitrequest, 1);
        c_valid = 1'b1; c_data = 32'hB0B0_0002;
        @(negedge clk); c_data = 32'hC0C0_0003; #1;
        chk("R9 second dword data", m_readdata, 32'hB0B0_0002);
        chk("R8 busy before last", m_waitrequest, 1);
        @(negedge clk); c_valid = 1'b0; #1;
        chk("R9 third dword data", m_readdata, 32'hC0C0_0003);
        chk("R9 third dword valid", m_readdatavalid, 1);
        chk("R8 released on last", m_waitrequest, 0);
        @(negedge clk); #1;
        chk("R9 no extra valid", m_readdatavalid, 0);
    endtask

    task automatic t_idle_completion();
        @(negedge clk);
        c_valid = 1'b1; c_data = 32'hDEAD_0000;
        @(negedge clk); c_valid = 1'b0; #1;
        chk("R9 idle completion ignored", m_readdatavalid, 0);
        chk("R9 idle stays idle", m_waitrequest, 0);
    endtask

    task automatic t_reset_busy();
        @(negedge clk);
        put(1, 0, 32'h0000_6000, 4'd1, 5'd2, 64'hFF);
        @(negedge clk); clear_bus();
        c_valid = 1'b1; c_data = 32'h1111_0001;
        @(negedge clk); c_valid = 1'b0; rst = 1'b1; #1;
        chk("R10 stall during reset", m_waitrequest, 1);
        @(negedge clk); rst = 1'b0; #1;
        chk("R10 outstanding read cleared", m_waitrequest, 0);
        c_valid = 1'b1; c_data = 32'h2222_0002;
        @(negedge clk); c_valid = 1'b0; #1;
        chk("R10 late completion dropped", m_readdatavalid, 0);
        put(0, 1, 32'h0000_7000, 4'd1, 5'd1, 64'hF); #1;
        chk("R10 write taken after reset", q_valid & ~m_waitrequest, 1);
        @(negedge clk); clear_bus();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_writes();
        t_bad("R1 burst 2", 0, 1, 32'h0, 4'd2, 5'd1, 64'hF);
        t_bad("R1 burst 0", 1, 0, 32'h0, 4'd0, 5'd1, 64'hF);
        t_bad("R2 length 0", 0, 1, 32'h0, 4'd1, 5'd0, 64'hF);
        t_bad("R2 length 17", 0, 1, 32'h0, 4'd1, 5'd17, {64{1'b1}});
        t_bad("R3 offset 15 length 2", 0, 1, 32'h3C, 4'd1, 5'd2, 64'hFF);
        t_bad("R3 offset 8 length 9", 1, 0, 32'h120, 4'd1, 5'd9, {64{1'b1}});
        t_bad("R5 partial be multi", 0, 1, 32'h0, 4'd1, 5'd2, 64'h3F);
        t_bad("R6 read and write", 1, 1, 32'h0, 4'd1, 5'd1, 64'hF);
        t_good_edge("R3 offset 15 length 1", 32'h3C, 5'd1);
        t_good_edge("R3 offset 0 length 16", 32'h40, 5'd16);
        t_good_edge("R2 length 16 offset 0", 32'h0, 5'd16);
        t_read();
        t_idle_completion();
        t_reset_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule